// File: doc/BRIEF.md
# Region Boundary Hint Recorder

This per-core block cuts execution into regions that all cores share in one global order. Each time a region closes, the block writes a hint record holding the region's sequence number and the core's running count of retired memory operations. An offline tool later uses these hints to bound how much of the execution it must analyse at once.

A region can close for three reasons, and more than one may apply at once. The elapsed-cycle trigger fires after a set number of enabled cycles, with no need to talk to other cores. The downgrade trigger fires when the number of coherence downgrade requests counted since the last boundary reaches a limit. A boundary pulse arriving from another core also closes the local region. Whichever trigger fires first closes the region and restarts both counters. A locally caused boundary drives a one-cycle pulse that can be broadcast to the other cores. Records wait in a small queue and leave through a valid/ready handshake. The trigger settings are taken from the configuration inputs only while the block is disabled.

Top module: `rbh_recorder`

## Requirements
- R1: After reset, `hint_valid` and `boundary_pulse` are low.
- R2: With the cycle trigger selected (`cfg_mode` bit 0) and a nonzero period P, a boundary closes in the P-th enabled cycle after enabling or after the previous boundary. `boundary_pulse` is high in the following cycle only.
- R3: With the downgrade trigger selected (`cfg_mode` bit 1) and a nonzero limit L, a boundary closes in the cycle of the L-th `downgrade_req` strobe counted since the previous boundary. `boundary_pulse` is high in the following cycle.
- R4: When both triggers are selected, the first one to fire closes the region and clears both counters. A downgrade strobe that arrives in a boundary cycle is not counted.
- R5: A `peer_boundary` strobe while enabled closes the region and produces a record. It does not raise `boundary_pulse` unless a local trigger fires in the same cycle.
- R6: Each record carries three fields. `hint_seq` starts at 0 and steps by one for each boundary. `hint_ops` is the number of `memop_retire` strobes since enabling, including the boundary cycle. `hint_cause` has bit 0 for the cycle trigger, bit 1 for the downgrade trigger and bit 2 for a peer boundary.
- R7: A period or limit of zero disables that trigger, even if its mode bit is set.
- R8: Mode, period and limit are taken from the configuration inputs only while `enable` is low, and changes made while enabled have no effect. Lowering `enable` clears the sequence number, the operation count and both trigger counters.
- R9: Records leave in the order of their boundaries. A record offered while `hint_ready` is low stays unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the recorder; while low, configuration is loaded |
| cfg_mode | input | 2 | Bit 0 selects the cycle trigger; bit 1 selects the downgrade trigger |
| cfg_period | input | PER_W | Number of cycles per region for the cycle trigger (0 disables it) |
| cfg_dg_limit | input | DG_W | Number of downgrades per region for the downgrade trigger (0 disables it) |
| memop_retire | input | 1 | One memory operation retired this cycle |
| downgrade_req | input | 1 | One coherence downgrade request this cycle |
| peer_boundary | input | 1 | Boundary pulse from another core |
| boundary_pulse | output | 1 | One-cycle pulse after a locally triggered boundary |
| hint_valid | output | 1 | A hint record is offered |
| hint_ready | input | 1 | Consumer accepts the offered record |
| hint_seq | output | SEQ_W | Region sequence number |
| hint_ops | output | OPS_W | Memory-operation count at the boundary |
| hint_cause | output | 3 | Trigger flags for the boundary |

## Verification
The queue-overflow property assumes that the consumer drains records at least as fast as boundaries occur over any window of queue depth. The stimulus meets this by spacing boundaries several cycles apart and by holding `hint_ready` low only for short stretches. The ordering properties assume that the running operation count does not wrap within a test, and the stimulus stays far below that range. Configuration changes are made both while disabled and mid-run, so that the held settings are exercised against the live inputs.

// File: rtl/rbh_pkg.sv
package rbh_pkg;
    parameter int SEQ_W = 16;
    parameter int OPS_W = 32;

    typedef struct packed {
        logic [2:0]       cause;
        logic [SEQ_W-1:0] seq;
        logic [OPS_W-1:0] ops;
    } hint_rec_t;

    localparam int REC_W = $bits(hint_rec_t);
endpackage

// File: rtl/rbh_trigger.sv
module rbh_trigger #(
    parameter int PER_W = 16,
    parameter int DG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       cfg_mode,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [DG_W-1:0]  cfg_dg_limit,
    input  logic             downgrade_req,
    input  logic             peer_boundary,
    output logic             fire,
    output logic             local_fire,
    output logic [2:0]       cause
);
    localparam logic [PER_W-1:0] PER_ONE = PER_W'(1);
    localparam logic [DG_W-1:0]  DG_ONE  = DG_W'(1);

    typedef struct packed {
        logic [1:0]       mode;
        logic [PER_W-1:0] period;
        logic [DG_W-1:0]  limit;
        logic [PER_W-1:0] cyc;
        logic [DG_W-1:0]  dg;
    } trig_st_t;

    trig_st_t st_d, st_q;
    logic cyc_on, dg_on, cyc_hit, dg_hit;

    always_comb begin
        st_d    = st_q;
        cyc_hit = 1'b0;
        dg_hit  = 1'b0;
        cyc_on  = st_q.mode[0] && (st_q.period != '0);
        dg_on   = st_q.mode[1] && (st_q.limit != '0);
        if (!enable) begin
            st_d.mode   = cfg_mode;
            st_d.period = cfg_period;
            st_d.limit  = cfg_dg_limit;
            st_d.cyc    = '0;
            st_d.dg     = '0;
        end else begin
            cyc_hit = cyc_on && (st_q.cyc == st_q.period - PER_ONE);
            dg_hit  = dg_on && downgrade_req && (st_q.dg == st_q.limit - DG_ONE);
            if (cyc_hit || dg_hit || peer_boundary) begin
                st_d.cyc = '0;
                st_d.dg  = '0;
            end else begin
                if (cyc_on) st_d.cyc = st_q.cyc + PER_ONE;
                if (dg_on && downgrade_req) st_d.dg = st_q.dg + DG_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause      = {enable && peer_boundary, dg_hit, cyc_hit};
    assign fire       = |cause;
    assign local_fire = cyc_hit || dg_hit;

    // R2: the cycle counter never passes its period while running
    p_cyc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cyc_on) |-> (st_q.cyc < st_q.period));

    // R3: the downgrade counter stays below its limit
    p_dg_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && dg_on) |-> (st_q.dg < st_q.limit));

    // R8: held settings do not move while running
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> ($stable(st_q.period) && $stable(st_q.limit) && $stable(st_q.mode)));
endmodule

// File: rtl/rbh_hint_fifo.sv
module rbh_hint_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_MAX);
    assign dout  = st_q.mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        if (do_push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + PTR_ONE;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + PTR_ONE;
        end
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + CNT_ONE;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a record is never lost to a full queue
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);
endmodule

// File: rtl/rbh_recorder.sv
module rbh_recorder
    import rbh_pkg::*;
#(
    parameter int PER_W      = 16,
    parameter int DG_W       = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       cfg_mode,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [DG_W-1:0]  cfg_dg_limit,
    input  logic             memop_retire,
    input  logic             downgrade_req,
    input  logic             peer_boundary,
    output logic             boundary_pulse,
    output logic             hint_valid,
    input  logic             hint_ready,
    output logic [SEQ_W-1:0] hint_seq,
    output logic [OPS_W-1:0] hint_ops,
    output logic [2:0]       hint_cause
);
    localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

    typedef struct packed {
        logic [OPS_W-1:0] ops;
        logic [SEQ_W-1:0] seq;
        logic             pulse;
    } rec_st_t;

    rec_st_t st_d, st_q;
    logic fire, local_fire, fifo_empty, fifo_full, pop;
    logic [2:0] cause;
    logic [OPS_W-1:0] ops_now;
    hint_rec_t rec_in, rec_out;

    rbh_trigger #(.PER_W(PER_W), .DG_W(DG_W)) trig_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .cfg_mode     (cfg_mode),
        .cfg_period   (cfg_period),
        .cfg_dg_limit (cfg_dg_limit),
        .downgrade_req(downgrade_req),
        .peer_boundary(peer_boundary),
        .fire         (fire),
        .local_fire   (local_fire),
        .cause        (cause)
    );

    assign ops_now = st_q.ops + {{(OPS_W-1){1'b0}}, memop_retire};
    assign rec_in  = '{cause: cause, seq: st_q.seq, ops: ops_now};

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.ops   = '0;
            st_d.seq   = '0;
            st_d.pulse = 1'b0;
        end else begin
            st_d.ops   = ops_now;
            st_d.pulse = local_fire;
            if (fire) st_d.seq = st_q.seq + SEQ_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop = hint_valid && hint_ready;

    rbh_hint_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) fifo_i (
        .clk  (clk),
        .rst_n(rst_n),
        .push (fire),
        .din  (rec_in),
        .pop  (pop),
        .dout (rec_out),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    assign hint_valid     = !fifo_empty;
    assign hint_seq       = rec_out.seq;
    assign hint_ops       = rec_out.ops;
    assign hint_cause     = rec_out.cause;
    assign boundary_pulse = st_q.pulse;

    // R6: each boundary advances the region number by one
    p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (st_q.seq == $past(st_q.seq) + SEQ_ONE));

    // R5: a boundary caused only by a peer is not echoed
    p_peer_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cause == 3'b100) |=> !boundary_pulse);

    // R9: an offered record holds until taken
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_valid && !hint_ready) |=>
            (hint_valid && $stable(hint_seq) && $stable(hint_ops) && $stable(hint_cause)));

    // R1: nothing is offered straight out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !boundary_pulse);
endmodule

// File: tb/rbh_recorder_tb_top.sv
`timescale 1ns/1ps
module rbh_recorder_tb_top;
    import rbh_pkg::*;
    localparam int PER_W = 16;
    localparam int DG_W  = 8;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, enable, memop_retire, downgrade_req, peer_boundary, hint_ready;
    logic [1:0] cfg_mode;
    logic [PER_W-1:0] cfg_period;
    logic [DG_W-1:0] cfg_dg_limit;
    logic boundary_pulse, hint_valid;
    logic [SEQ_W-1:0] hint_seq;
    logic [OPS_W-1:0] hint_ops;
    logic [2:0] hint_cause;

    rbh_recorder #(.PER_W(PER_W), .DG_W(DG_W), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_mode(cfg_mode),
        .cfg_period(cfg_period), .cfg_dg_limit(cfg_dg_limit),
        .memop_retire(memop_retire), .downgrade_req(downgrade_req),
        .peer_boundary(peer_boundary), .boundary_pulse(boundary_pulse),
        .hint_valid(hint_valid), .hint_ready(hint_ready), .hint_seq(hint_seq),
        .hint_ops(hint_ops), .hint_cause(hint_cause)
    );

    int checks = 0;
    int errors = 0;
    int phase_pops = 0;
    string req_tag = "R1";
    bit done = 1'b0;

    typedef struct {
        logic [2:0]       cause;
        logic [SEQ_W-1:0] seq;
        logic [OPS_W-1:0] ops;
    } exp_t;
    exp_t expq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard model built from the requirements
    logic [1:0] m_mode;
    int m_per, m_lim, m_cyc, m_dg, m_seq, m_ops;
    bit exp_pulse;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_per = 0; m_lim = 0; m_cyc = 0; m_dg = 0;
            m_seq = 0; m_ops = 0; exp_pulse = 0;
        end else if (!enable) begin
            m_mode = cfg_mode; m_per = cfg_period; m_lim = cfg_dg_limit;
            m_cyc = 0; m_dg = 0; m_seq = 0; m_ops = 0; exp_pulse = 0;
        end else begin
            bit c_on, d_on, c_hit, d_hit;
            exp_t e;
            c_on  = m_mode[0] && m_per != 0;
            d_on  = m_mode[1] && m_lim != 0;
            m_ops = m_ops + int'(memop_retire);
            c_hit = c_on && (m_cyc + 1 == m_per);
            d_hit = d_on && downgrade_req && (m_dg + 1 == m_lim);
            exp_pulse = c_hit || d_hit;
            if (c_hit || d_hit || peer_boundary) begin
                e.cause = {peer_boundary, d_hit, c_hit};
                e.seq   = SEQ_W'(m_seq);
                e.ops   = OPS_W'(m_ops);
                expq.push_back(e);
                m_seq++;
                m_cyc = 0;
                m_dg  = 0;
            end else begin
                if (c_on) m_cyc++;
                if (d_on && downgrade_req) m_dg++;
            end
        end
    end

    // Monitor: compares accepted records and pulses
    bit stall_seen = 1'b0;
    logic [SEQ_W-1:0] st_seq;
    logic [OPS_W-1:0] st_ops;
    logic [2:0] st_cause;
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_pulse || boundary_pulse)
                check(boundary_pulse === exp_pulse, {req_tag, "/R2/R3"}, "boundary_pulse",
                      64'(boundary_pulse), 64'(exp_pulse));
            if (stall_seen)
                check(hint_valid && hint_seq == st_seq && hint_ops == st_ops &&
                      hint_cause == st_cause, "R9", "held record",
                      {hint_cause, hint_seq, hint_ops}, {st_cause, st_seq, st_ops});
            stall_seen = hint_valid && !hint_ready;
            st_seq = hint_seq; st_ops = hint_ops; st_cause = hint_cause;
            if (hint_valid && hint_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, {req_tag, "/R6"}, "unexpected record",
                          {hint_cause, hint_seq, hint_ops}, 64'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(hint_cause == e.cause && hint_seq == e.seq && hint_ops == e.ops,
                          {req_tag, "/R6"}, "record {cause,seq,ops}",
                          {hint_cause, hint_seq, hint_ops}, {e.cause, e.seq, e.ops});
                end
                phase_pops++;
            end
        end
    end

    task automatic drive(input bit r, input bit d, input bit p);
        memop_retire = r; downgrade_req = d; peer_boundary = p;
        @(negedge clk);
    endtask

    task automatic configure(input logic [1:0] m, input int per, input int lim);
        enable = 1'b0; cfg_mode = m; cfg_period = PER_W'(per); cfg_dg_limit = DG_W'(lim);
        memop_retire = 0; downgrade_req = 0; peer_boundary = 0;
        repeat (2) @(negedge clk);
        phase_pops = 0;
        enable = 1'b1;
    endtask

    task automatic finish_phase(input string req, input int exp_pops);
        enable = 1'b0; memop_retire = 0; downgrade_req = 0; peer_boundary = 0;
        hint_ready = 1'b1;
        for (int i = 0; i < 20 && hint_valid; i++) @(negedge clk);
        @(negedge clk);
        check(phase_pops == exp_pops, req, "records in phase", 64'(phase_pops), 64'(exp_pops));
        check(expq.size() == 0, req, "scoreboard drained", 64'(expq.size()), 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; enable = 0; cfg_mode = 0; cfg_period = 0; cfg_dg_limit = 0;
        memop_retire = 0; downgrade_req = 0; peer_boundary = 0; hint_ready = 1;
        repeat (3) @(negedge clk);
        check(!hint_valid && !boundary_pulse, "R1", "outputs in reset",
              {hint_valid, boundary_pulse}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check(!hint_valid && !boundary_pulse, "R1", "outputs after reset",
              {hint_valid, boundary_pulse}, 64'd0);

        // R2: period 5, thirty cycles -> six boundaries
        req_tag = "R2";
        configure(2'b01, 5, 0);
        for (int k = 0; k < 30; k++) drive((k % 3) != 0, k == 7, 1'b0);
        finish_phase("R2", 6);

        // R3: limit 3, nine downgrades -> three boundaries
        req_tag = "R3";
        configure(2'b10, 0, 3);
        for (int k = 0; k < 20; k++)
            drive(k[0], k inside {1, 2, 4, 6, 7, 9, 10, 11, 12}, 1'b0);
        finish_phase("R3", 3);

        // R4: both triggers, period 8 and limit 2
        req_tag = "R4";
        configure(2'b11, 8, 2);
        for (int k = 0; k < 20; k++)
            drive(1'b1, k inside {3, 5, 13, 15, 16}, 1'b0);
        finish_phase("R4", 3);

        // R5: peer strobes only
        req_tag = "R5";
        configure(2'b00, 5, 2);
        for (int k = 0; k < 16; k++) drive(k > 4, k == 1, k inside {2, 6, 7, 12});
        finish_phase("R5", 4);

        // R7: zero period disables the cycle trigger
        req_tag = "R7";
        configure(2'b11, 0, 2);
        for (int k = 0; k < 40; k++) drive(1'b1, (k % 6) == 5, 1'b0);
        finish_phase("R7", 3);

        // R8: changes while enabled are ignored
        req_tag = "R8";
        configure(2'b01, 4, 0);
        for (int k = 0; k < 16; k++) begin
            if (k == 3) begin cfg_period = 2; cfg_mode = 2'b10; cfg_dg_limit = 1; end
            drive(k[1], 1'b1, 1'b0);
        end
        finish_phase("R8", 4);

        // R9: back-pressure with period 6
        req_tag = "R9";
        configure(2'b01, 6, 0);
        for (int k = 0; k < 36; k++) begin
            hint_ready = (k % 10) >= 4;
            drive(1'b1, 1'b0, 1'b0);
        end
        finish_phase("R9", 6);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule